// File: doc/BRIEF.md
# Parallel Port Extended-Mode FIFO Controller

This block holds the extended control register and a 16-byte data FIFO for an IEEE 1284 style parallel port. A host reaches it over a byte-wide register bus: address 0 is the FIFO data window, address 1 is the port control register (bit 0 selects direction), and address 2 is the extended control register with mode, DMA enable, error-interrupt mask and the service latch. The peripheral side sees the FIFO as two byte streams: an outbound stream in forward direction and an inbound stream in reverse direction. In each case the accepted rules are valid/ready. A beat moves on a clock edge where both are high. The sender holds data and valid until it is accepted. The block drops `out_valid` only when the FIFO drains and drops `in_ready` only when it fills.

The service latch arms work in an unusual way. While it reads 0 it watches for one of three events. Which one it watches depends on whether DMA is enabled and on the direction: a terminal count, 8 or more free slots, or 8 or more bytes held. When that event occurs the latch sets itself to 1 and pulses the interrupt request for one cycle. While it reads 1 it blocks those events and the DMA request. The host rearms it by writing 0 to its bit. A DMA engine moves bytes with a request/acknowledge pair, and it marks the last byte with a terminal-count strobe.

Top module: `ecpf_top`

## Requirements
- R1: After reset the extended control register reads 0x15: mode 000, DMA off, error interrupt masked, service bit 1, FIFO empty, not full. `irq` and `dma_req` are low.
- R2: The extended control register (address 2) reads as follows: bit 0 is FIFO empty, bit 1 is FIFO full, bit 2 is the service bit, bit 3 is DMA enable, bit 4 is the error mask, and bits 7:5 are the mode. Writes to bits 1:0 are ignored.
- R3: The FIFO holds 16 bytes in first-in first-out order. A push while full is dropped, and a pop while empty changes nothing.
- R4: Writing 0 to bit 2 clears the service bit. Writing 1 to bit 2 leaves it unchanged.
- R5: With the service bit 0, DMA off and direction 0, reaching 8 or more free slots sets the service bit on the next clock edge and pulses `irq` for one cycle.
- R6: With the service bit 0, DMA off and direction 1, holding 8 or more bytes sets the service bit on the next clock edge and pulses `irq` for one cycle.
- R7: With the service bit 0 and DMA on, a `dma_ack` together with `dma_tc` sets the service bit at that edge and pulses `irq` for one cycle.
- R8: While the service bit is 1, `dma_req` is low and no threshold or terminal-count pulse appears on `irq`.
- R9: `dma_req` is high only when DMA is on, the service bit is 0 and the mode is 010 or 011. In direction 0 the FIFO must also be not full, and in direction 1 it must be not empty.
- R10: A write that changes the mode to 000 or 001 empties the FIFO. A change to any other mode keeps its contents.
- R11: While the error mask is 0, `irq` follows `fault` combinationally. While the mask is 1, `fault` has no effect.
- R12: In direction 0 the host writes at address 0 and DMA acknowledges push, and the outbound stream pops. In direction 1 the inbound stream pushes, and host reads at address 0 and DMA acknowledges pop. Address 1 bit 0 reads back the direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Host register address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (pops FIFO at address 0 in reverse) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |
| fault | input | 1 | Peripheral error line, active high |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one byte per cycle |
| dma_tc | input | 1 | Terminal count, valid with `dma_ack` |
| dma_wdata | input | 8 | DMA byte to push in forward direction |
| dma_rdata | output | 8 | FIFO head byte for DMA in reverse direction |
| out_valid | output | 1 | Outbound stream valid |
| out_ready | input | 1 | Outbound stream ready |
| out_data | output | 8 | Outbound stream byte |
| in_valid | input | 1 | Inbound stream valid |
| in_ready | output | 1 | Inbound stream ready |
| in_data | input | 8 | Inbound stream byte |

## Verification
The assertions assume a few things about the inputs. The DMA engine acknowledges only while `dma_req` is high. An acknowledge never falls in the same cycle as a host access to the FIFO window. The direction bit does not change while bytes are in flight. The stimulus holds to these rules in three ways. Each scenario drives one source at a time on the falling edge. DMA acknowledges are issued only after the bench has seen `dma_req` high. The direction is switched only while the FIFO is empty or the service bit blocks events.

// File: rtl/ecpf_pkg.sv
package ecpf_pkg;
  typedef enum logic [2:0] {
    M_PIO_COMPAT = 3'b000,
    M_PIO_NIBBLE = 3'b001,
    M_DMA_COMPAT = 3'b010,
    M_DMA_ECP    = 3'b011,
    M_EPP        = 3'b100,
    M_RSVD       = 3'b101,
    M_TEST_FIFO  = 3'b110,
    M_CONFIG     = 3'b111
  } port_mode_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_XCTL = 2'd2;

  function automatic logic mode_uses_dma(port_mode_e m);
    return (m == M_DMA_COMPAT) || (m == M_DMA_ECP);
  endfunction

  function automatic logic mode_flushes(port_mode_e m);
    return (m == M_PIO_COMPAT) || (m == M_PIO_NIBBLE);
  endfunction
endpackage

// File: rtl/ecpf_fifo.sv
module ecpf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          push,
  input  logic [DW-1:0]                 push_data,
  input  logic                          pop,
  output logic [DW-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          empty,
  output logic                          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp_q];
  assign count   = cnt_q;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wp_nx = wp_q + 1'b1;
      assign rp_nx = rp_q + 1'b1;
    end else begin : g_wrap
      assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_nx;
      if (pop_ok)  rp_q <= rp_nx;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3: occupancy never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R3: a push into a full FIFO with no pop leaves occupancy unchanged
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));
  // R10: a flush leaves the FIFO empty
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/ecpf_ctl_regs.sv
module ecpf_ctl_regs
  import ecpf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_xctl,
  input  logic                        wr_ctrl,
  input  logic [7:2]                  xctl_wd,
  input  logic                        dir_wd,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  input  logic                        tc_hit,
  input  logic                        fault,
  output port_mode_e                  mode,
  output logic                        dma_en,
  output logic                        err_mask,
  output logic                        srv,
  output logic                        dir,
  output logic                        flush,
  output logic                        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  port_mode_e    mode_q;
  logic          dma_q, mask_q, srv_q, dir_q, pulse_q;
  logic [CW-1:0] free_slots;
  logic          ev_fwd, ev_rev, ev_tc, ev_any, srv_clr, srv_set;
  port_mode_e    mode_wd;

  assign mode_wd    = port_mode_e'(xctl_wd[7:5]);
  assign free_slots = CW'(DEPTH) - count;
  assign ev_fwd     = !dma_q && !dir_q && (free_slots >= CW'(THRESH));
  assign ev_rev     = !dma_q &&  dir_q && (count >= CW'(THRESH));
  assign ev_tc      =  dma_q && tc_hit;
  assign ev_any     = ev_fwd || ev_rev || ev_tc;
  assign srv_clr    = wr_xctl && !xctl_wd[2];
  assign srv_set    = !srv_q && ev_any && !srv_clr;
  assign flush      = wr_xctl && (mode_wd != mode_q) && mode_flushes(mode_wd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_PIO_COMPAT;
      dma_q   <= 1'b0;
      mask_q  <= 1'b1;
      srv_q   <= 1'b1;
      dir_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_xctl) begin
        mode_q <= mode_wd;
        mask_q <= xctl_wd[4];
        dma_q  <= xctl_wd[3];
      end
      if (wr_ctrl) dir_q <= dir_wd;
      if (srv_clr)      srv_q <= 1'b0;
      else if (srv_set) srv_q <= 1'b1;
      pulse_q <= srv_set;
    end
  end

  assign mode     = mode_q;
  assign dma_en   = dma_q;
  assign err_mask = mask_q;
  assign srv      = srv_q;
  assign dir      = dir_q;
  assign irq      = pulse_q || (fault && !mask_q);

  // R4: the service bit only falls after a host write of 0 to it
  a_r4_clear_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srv_q) |-> $past(wr_xctl && !xctl_wd[2]));
  // R8: no service pulse follows a cycle in which the latch was already set
  a_r8_no_pulse_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    srv_q |=> !pulse_q);
  // R5/R6/R7: a service pulse always comes with the latch set
  a_r5_pulse_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> srv_q);
  // R11: with the mask set, fault cannot reach irq outside a service pulse
  a_r11_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !pulse_q) |-> !irq);
endmodule

// File: rtl/ecpf_top.sv
module ecpf_top
  import ecpf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       fault,
  output logic       dma_req,
  input  logic       dma_ack,
  input  logic       dma_tc,
  input  logic [7:0] dma_wdata,
  output logic [7:0] dma_rdata,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data
);
  localparam int CW = $clog2(DEPTH + 1);

  port_mode_e    mode;
  logic          dma_en, err_mask, srv, dir, flush;
  logic          f_push, f_pop, f_empty, f_full;
  logic [7:0]    f_wdata, f_head;
  logic [CW-1:0] f_count;
  logic          host_data_wr, host_data_rd;

  assign host_data_wr = wr_en && (addr == A_DATA);
  assign host_data_rd = rd_en && (addr == A_DATA);

  ecpf_ctl_regs #(.DEPTH(DEPTH), .THRESH(THRESH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_xctl  (wr_en && (addr == A_XCTL)),
    .wr_ctrl  (wr_en && (addr == A_CTRL)),
    .xctl_wd  (wdata[7:2]),
    .dir_wd   (wdata[0]),
    .count    (f_count),
    .tc_hit   (dma_ack && dma_tc),
    .fault    (fault),
    .mode     (mode),
    .dma_en   (dma_en),
    .err_mask (err_mask),
    .srv      (srv),
    .dir      (dir),
    .flush    (flush),
    .irq      (irq)
  );

  always_comb begin
    if (!dir) begin
      f_push  = host_data_wr || dma_ack;
      f_wdata = dma_ack ? dma_wdata : wdata;
      f_pop   = out_valid && out_ready;
    end else begin
      f_push  = in_valid && in_ready;
      f_wdata = in_data;
      f_pop   = host_data_rd || dma_ack;
    end
  end

  ecpf_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (f_push),
    .push_data (f_wdata),
    .pop       (f_pop),
    .head      (f_head),
    .count     (f_count),
    .empty     (f_empty),
    .full      (f_full)
  );

  assign out_valid = !dir && !f_empty;
  assign out_data  = f_head;
  assign in_ready  = dir && !f_full;
  assign dma_rdata = f_head;
  assign dma_req   = dma_en && !srv && mode_uses_dma(mode) &&
                     (dir ? !f_empty : !f_full);

  always_comb begin
    case (addr)
      A_DATA:  rdata = f_head;
      A_CTRL:  rdata = {7'd0, dir};
      A_XCTL:  rdata = {mode, err_mask, dma_en, srv, f_full, f_empty};
      default: rdata = 8'd0;
    endcase
  end

  // R8: a set service latch holds the DMA request low
  a_r8_no_req_when_srv: assert property (@(posedge clk) disable iff (!rst_n)
    srv |-> !dma_req);
  // R9: programmed-I/O and other non-DMA modes never request DMA
  a_r9_no_req_pio: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_uses_dma(mode) |-> !dma_req);
  // R3: the outbound stream never offers a byte from an empty FIFO
  a_r3_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !f_empty);
endmodule

// File: tb/sim_ecpf_top.sv
`timescale 1ns/1ps
module sim_ecpf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, fault = 1'b0;
  logic       dma_req, dma_ack = 1'b0, dma_tc = 1'b0;
  logic [7:0] dma_wdata = '0, dma_rdata;
  logic       out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecpf_top u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic hrd(output logic [7:0] v);
    @(negedge clk); addr = 2'd0; rd_en = 1'b1; #1 v = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic in_push(input logic [7:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic out_pop(output logic v, output logic [7:0] d);
    @(negedge clk); out_ready = 1'b1; #1 v = out_valid; d = out_data;
    @(posedge clk); #1 out_ready = 1'b0;
  endtask

  task automatic dack(input logic [7:0] d, input logic tc, output logic [7:0] rd);
    @(negedge clk); dma_ack = 1'b1; dma_wdata = d; dma_tc = tc; #1 rd = dma_rdata;
    @(posedge clk); #1 begin dma_ack = 1'b0; dma_tc = 1'b0; end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(2'd2, v); chk("R1 xctl reset", v, 8'h15);
    chk("R1 irq reset", {7'd0, irq}, 8'd0);
    chk("R1 dma_req reset", {7'd0, dma_req}, 8'd0);
  endtask

  task automatic t_fields;
    logic [7:0] v;
    hwr(2'd2, 8'h07);
    peek(2'd2, v); chk("R2 R4 low bits ignored, set-write no effect", v, 8'h05);
    hwr(2'd2, 8'h14);
    peek(2'd2, v); chk("R2 mask readback", v, 8'h15);
  endtask

  task automatic t_fifo_fwd;
    logic [7:0] v; logic ok;
    for (int i = 0; i < 16; i++) hwr(2'd0, 8'h40 + 8'(i));
    peek(2'd2, v); chk("R2 R3 full flag", v, 8'h16);
    hwr(2'd0, 8'hEE);
    for (int i = 0; i < 16; i++) begin
      out_pop(ok, v);
      chk("R12 out valid", {7'd0, ok}, 8'd1);
      chk("R3 fifo order", v, 8'h40 + 8'(i));
    end
    #1 chk("R3 overflow byte dropped", {7'd0, out_valid}, 8'd0);
  endtask

  task automatic t_fwd_thresh;
    logic [7:0] v; logic ok;
    for (int i = 0; i < 9; i++) hwr(2'd0, 8'h60 + 8'(i));
    hwr(2'd2, 8'h10);
    peek(2'd2, v); chk("R4 clear by zero", v & 8'h04, 8'h00);
    repeat (2) @(posedge clk); #1;
    chk("R5 no fire at 7 free", {7'd0, irq}, 8'd0);
    out_pop(ok, v);
    peek(2'd2, v); chk("R5 not yet", v & 8'h04, 8'h00);
    @(posedge clk); #1;
    chk("R5 irq pulse", {7'd0, irq}, 8'd1);
    peek(2'd2, v); chk("R5 srv set", v & 8'h04, 8'h04);
    @(posedge clk); #1;
    chk("R5 pulse one cycle", {7'd0, irq}, 8'd0);
    hwr(2'd2, 8'h34);
    peek(2'd2, v); chk("R10 flush on mode 001", v, 8'h35);
    hwr(2'd2, 8'h14);
  endtask

  task automatic t_reverse;
    logic [7:0] v;
    hwr(2'd1, 8'h01);
    peek(2'd1, v); chk("R12 direction readback", v, 8'h01);
    hwr(2'd2, 8'h10);
    for (int i = 0; i < 7; i++) in_push(8'hA0 + 8'(i));
    @(posedge clk); #1;
    peek(2'd2, v); chk("R6 no fire at 7 held", v & 8'h04, 8'h00);
    in_push(8'hA7);
    peek(2'd2, v); chk("R6 not yet", v & 8'h04, 8'h00);
    @(posedge clk); #1;
    chk("R6 irq pulse", {7'd0, irq}, 8'd1);
    peek(2'd2, v); chk("R6 srv set", v & 8'h04, 8'h04);
    for (int i = 0; i < 8; i++) begin
      hrd(v); chk("R12 R3 reverse read order", v, 8'hA0 + 8'(i));
    end
    hrd(v);
    peek(2'd2, v); chk("R3 pop on empty", v, 8'h15);
    hwr(2'd1, 8'h00);
  endtask

  task automatic t_dma;
    logic [7:0] v; logic ok;
    hwr(2'd2, 8'h5C);
    #1 chk("R8 req blocked by srv", {7'd0, dma_req}, 8'd0);
    repeat (3) @(posedge clk); #1;
    chk("R8 no irq while srv", {7'd0, irq}, 8'd0);
    hwr(2'd2, 8'h58);
    #1 chk("R9 req fwd not full", {7'd0, dma_req}, 8'd1);
    for (int i = 0; i < 16; i++) dack(8'hC0 + 8'(i), 1'b0, v);
    #1 chk("R9 req low when full", {7'd0, dma_req}, 8'd0);
    peek(2'd2, v); chk("R5 no threshold with dma on", v & 8'h04, 8'h00);
    for (int i = 0; i < 16; i++) begin
      out_pop(ok, v); chk("R12 dma forward data", v, 8'hC0 + 8'(i));
    end
    #1 chk("R9 req back", {7'd0, dma_req}, 8'd1);
    dack(8'hD0, 1'b1, v);
    chk("R7 irq on tc", {7'd0, irq}, 8'd1);
    chk("R7 R8 req drops", {7'd0, dma_req}, 8'd0);
    peek(2'd2, v); chk("R7 srv set", v & 8'h04, 8'h04);
    @(posedge clk); #1 chk("R7 pulse one cycle", {7'd0, irq}, 8'd0);
    hwr(2'd2, 8'h1C);
    peek(2'd2, v); chk("R10 flush on mode 000", v & 8'h01, 8'h01);
    #1 chk("R9 no req in pio", {7'd0, dma_req}, 8'd0);
    hwr(2'd1, 8'h01);
    hwr(2'd2, 8'h58);
    #1 chk("R9 reverse empty no req", {7'd0, dma_req}, 8'd0);
    in_push(8'hA5);
    chk("R9 reverse req", {7'd0, dma_req}, 8'd1);
    hwr(2'd2, 8'h7C);
    peek(2'd2, v); chk("R10 no flush to 011", v & 8'h01, 8'h00);
    hwr(2'd2, 8'h78);
    dack(8'h00, 1'b0, v); chk("R12 dma reverse data", v, 8'hA5);
    #1 chk("R9 req low when empty", {7'd0, dma_req}, 8'd0);
  endtask

  task automatic t_fault;
    hwr(2'd2, 8'h04);
    chk("R11 idle irq", {7'd0, irq}, 8'd0);
    fault = 1'b1; #1 chk("R11 fault unmasked", {7'd0, irq}, 8'd1);
    hwr(2'd2, 8'h14);
    chk("R11 fault masked", {7'd0, irq}, 8'd0);
    fault = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_fields();
    t_fifo_fwd();
    t_fwd_thresh();
    t_reverse();
    t_dma();
    t_fault();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule